// File: doc/BRIEF.md
# Table-Driven Sine PWM Generator

This block turns a single clock into a pulse-width modulated output whose duty follows one cycle of a sine-like curve. An 8-bit dual-slope carrier counts up to its maximum and back down to zero. Each time it comes back to zero it raises a one-cycle overflow strobe, and that strobe moves a 7-bit phase index forward by one step. The sample for the new phase is fetched from a 128-point waveform table held in logic. It is then placed in a 16-bit compare buffer whose upper byte is always zero.

The buffered value is copied into the active compare register only when the carrier turns at its top. Each carrier period therefore uses one steady duty value. A low-pass filter outside the block turns the pulse train into an analog sine whose frequency is the clock divided by 510 × 128. While the enable input is low the carrier and phase freeze, and the output and strobe stay low.

Top module: `sine_pwm_gen`

## Requirements
- R1: While reset is asserted, and right after it is asserted, `phase_o` reads 0 and `ovf_o` and `pwm_o` are low.
- R2: Counting only cycles with `en` high after reset, `ovf_o` is high in enabled cycle 510·k for every k ≥ 1 and low in all other cycles. One carrier period is therefore 510 enabled cycles, and enabled cycle 0 carries no strobe.
- R3: `phase_o` advances by exactly one on the clock edge that ends a cycle with `ovf_o` high. At every other edge it holds its value.
- R4: The phase index wraps from 127 to 0.
- R5: The output is non-inverting and dual-slope. For a period whose active compare value is c, `pwm_o` is high in 2c−1 of its 510 enabled cycles, in a single contiguous run centred on the carrier bottom. It is low throughout when c = 0.
- R6: Table entries 0 to 13 are 0,0,1,1,2,3,4,6,7,9,10,12,14,16.
- R7: Table entry 64 is 127, and no entry exceeds 127.
- R8: Entry 128−n equals entry n for n = 1..63, and the entries never decrease from index 0 to index 64.
- R9: The compare value reaches the output only at the carrier top. The k-th period counted from the first top after reset (k = 0, 1, …) uses table entry k mod 128, and period 0 uses the reset value 0.
- R10: While `en` is low, the carrier and `phase_o` hold their values and `pwm_o` and `ovf_o` are low. When `en` returns high, the sequence resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the carrier advances once per enabled cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Run enable; low freezes the block and silences the output |
| pwm_o | output | 1 | Sine-modulated pulse output |
| phase_o | output | 7 | Current phase index, 0 to 127 |
| ovf_o | output | 1 | One-cycle strobe when the carrier reaches bottom |

## Verification
The hardest condition to reach is the table wrap. The index only returns to 0 after 128 full carrier periods, more than 65,000 enabled cycles. Only then can the mirror symmetry and peak of the table be judged from the output alone. The stimulus therefore runs long enough for every phase to pass with enable dropped at random. It infers each period's compare value from the width of its pulse run, and directed enable-low stretches are placed exactly on an overflow cycle and on a carrier top. Those are the cycles where a frozen state could otherwise lose an update.

// File: rtl/sine_pwm_pkg.sv
`timescale 1ns/1ps
package sine_pwm_pkg;
  localparam int PH_W  = 7;
  localparam int SMP_W = 7;

  typedef logic [PH_W-1:0]  phase_t;
  typedef logic [SMP_W-1:0] sample_t;

  // Rising half of the waveform, indices 0..63; the top half is mirrored.
  function automatic sample_t half_curve(input logic [PH_W-2:0] idx);
    sample_t v;
    case (idx)
      6'd0:  v = 7'd0;   6'd1:  v = 7'd0;   6'd2:  v = 7'd1;   6'd3:  v = 7'd1;
      6'd4:  v = 7'd2;   6'd5:  v = 7'd3;   6'd6:  v = 7'd4;   6'd7:  v = 7'd6;
      6'd8:  v = 7'd7;   6'd9:  v = 7'd9;   6'd10: v = 7'd10;  6'd11: v = 7'd12;
      6'd12: v = 7'd14;  6'd13: v = 7'd16;  6'd14: v = 7'd18;  6'd15: v = 7'd20;
      6'd16: v = 7'd22;  6'd17: v = 7'd25;  6'd18: v = 7'd27;  6'd19: v = 7'd30;
      6'd20: v = 7'd32;  6'd21: v = 7'd35;  6'd22: v = 7'd38;  6'd23: v = 7'd41;
      6'd24: v = 7'd44;  6'd25: v = 7'd47;  6'd26: v = 7'd50;  6'd27: v = 7'd53;
      6'd28: v = 7'd56;  6'd29: v = 7'd59;  6'd30: v = 7'd62;  6'd31: v = 7'd65;
      6'd32: v = 7'd68;  6'd33: v = 7'd71;  6'd34: v = 7'd74;  6'd35: v = 7'd77;
      6'd36: v = 7'd80;  6'd37: v = 7'd83;  6'd38: v = 7'd86;  6'd39: v = 7'd89;
      6'd40: v = 7'd92;  6'd41: v = 7'd94;  6'd42: v = 7'd97;  6'd43: v = 7'd99;
      6'd44: v = 7'd102; 6'd45: v = 7'd104; 6'd46: v = 7'd106; 6'd47: v = 7'd108;
      6'd48: v = 7'd110; 6'd49: v = 7'd112; 6'd50: v = 7'd114; 6'd51: v = 7'd115;
      6'd52: v = 7'd117; 6'd53: v = 7'd118; 6'd54: v = 7'd119; 6'd55: v = 7'd120;
      6'd56: v = 7'd121; 6'd57: v = 7'd122; 6'd58: v = 7'd122; 6'd59: v = 7'd123;
      6'd60: v = 7'd124; 6'd61: v = 7'd125; 6'd62: v = 7'd126; 6'd63: v = 7'd126;
      default: v = 7'd0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/sine_pwm_rom.sv
`timescale 1ns/1ps
module sine_pwm_rom
  import sine_pwm_pkg::*;
(
  input  phase_t  addr_i,
  output sample_t data_o
);
  localparam phase_t PEAK_IDX = phase_t'(1) << (PH_W-1);

  logic [PH_W-2:0] mirror_lo;

  always_comb begin
    // 128 - idx for the upper half, taken modulo the half size
    mirror_lo = ~addr_i[PH_W-2:0] + 1'b1;
    if (addr_i == PEAK_IDX) begin
      data_o = '1;
    end else if (addr_i[PH_W-1]) begin
      data_o = half_curve(mirror_lo);
    end else begin
      data_o = half_curve(addr_i[PH_W-2:0]);
    end
  end
endmodule

// File: rtl/sine_pwm_carrier.sv
`timescale 1ns/1ps
module sine_pwm_carrier #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             top_o,
  output logic             bot_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (en) begin
      if (up_q) begin
        if (cnt_q == CNT_MAX) begin
          cnt_d = CNT_MAX - 1'b1;
          up_d  = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == CNT_MIN) begin
          cnt_d = CNT_MIN + 1'b1;
          up_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_MIN;
      up_q  <= 1'b1;
    end else if (en) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;
  assign top_o = en &&  up_q && (cnt_q == CNT_MAX);
  assign bot_o = en && !up_q && (cnt_q == CNT_MIN);
endmodule

// File: rtl/sine_pwm_phase.sv
`timescale 1ns/1ps
module sine_pwm_phase
  import sine_pwm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_i,
  output phase_t phase_o,
  output phase_t phase_nxt_o
);
  phase_t phase_q, phase_d, phase_inc;

  always_comb begin
    phase_inc = phase_q + 1'b1;
    phase_d   = step_i ? phase_inc : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (step_i) begin
      phase_q <= phase_d;
    end
  end

  assign phase_o     = phase_q;
  assign phase_nxt_o = phase_inc;
endmodule

// File: rtl/sine_pwm_cmp.sv
`timescale 1ns/1ps
module sine_pwm_cmp
  import sine_pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load_buf_i,
  input  sample_t          sample_i,
  input  logic             load_act_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             pwm_o,
  output logic [CMP_W-1:0] buf_o,
  output logic [CMP_W-1:0] act_o
);
  logic [CMP_W-1:0] buf_q, buf_d, act_q, act_d;
  logic [CMP_W-1:0] cnt_ext, sample_ext;

  always_comb begin
    sample_ext = CMP_W'(sample_i);  // upper byte held at zero
    cnt_ext    = CMP_W'(cnt_i);
    buf_d      = load_buf_i ? sample_ext : buf_q;
    act_d      = load_act_i ? buf_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (load_buf_i) buf_q <= buf_d;
      if (load_act_i) act_q <= act_d;
    end
  end

  assign pwm_o = en && (cnt_ext < act_q);
  assign buf_o = buf_q;
  assign act_o = act_q;
endmodule

// File: rtl/sine_pwm_gen.sv
`timescale 1ns/1ps
module sine_pwm_gen
  import sine_pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CMP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  output logic            pwm_o,
  output logic [PH_W-1:0] phase_o,
  output logic            ovf_o
);
  logic [1:0]       rst_pipe;
  logic             rst_n_sync;
  logic [CNT_W-1:0] cnt;
  logic             dir_up, top_evt, bot_evt;
  phase_t           phase_cur, phase_nxt;
  sample_t          sample;
  logic [CMP_W-1:0] cmp_buf, cmp_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  sine_pwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk(clk), .rst_n(rst_n_sync), .en(en),
    .cnt_o(cnt), .up_o(dir_up), .top_o(top_evt), .bot_o(bot_evt)
  );

  sine_pwm_phase u_phase (
    .clk(clk), .rst_n(rst_n_sync), .step_i(bot_evt),
    .phase_o(phase_cur), .phase_nxt_o(phase_nxt)
  );

  sine_pwm_rom u_rom (.addr_i(phase_nxt), .data_o(sample));

  sine_pwm_cmp #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_cmp (
    .clk(clk), .rst_n(rst_n_sync), .en(en),
    .load_buf_i(bot_evt), .sample_i(sample),
    .load_act_i(top_evt), .cnt_i(cnt),
    .pwm_o(pwm_o), .buf_o(cmp_buf), .act_o(cmp_act)
  );

  assign phase_o = phase_cur;
  assign ovf_o   = bot_evt;
endmodule

// File: rtl/sine_pwm_chk.sv
`timescale 1ns/1ps
module sine_pwm_chk
  import sine_pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CMP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pwm_o,
  input phase_t           phase_o,
  input logic             ovf_o,
  input logic [CNT_W-1:0] cnt,
  input logic             dir_up,
  input logic [CMP_W-1:0] cmp_buf,
  input logic [CMP_W-1:0] cmp_act
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CMP_W-1:0] DUTY_MAX = CMP_W'(127);

  p_ovf_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> !ovf_o);

  p_turn_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dir_up && cnt == CNT_MAX) |=> (!dir_up && cnt == CNT_MAX - 1'b1));

  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (phase_o == phase_t'($past(phase_o) + 1'b1)));

  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_o |=> $stable(phase_o));

  p_duty_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act <= DUTY_MAX) && (cmp_buf <= DUTY_MAX));

  p_act_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dir_up && cnt == CNT_MAX) |=> (cmp_act == $past(cmp_buf)));

  p_act_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && dir_up && cnt == CNT_MAX) |=> $stable(cmp_act));

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt) && $stable(dir_up) && $stable(phase_o)));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!pwm_o && !ovf_o));
endmodule

bind sine_pwm_gen sine_pwm_chk #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .en(en), .pwm_o(pwm_o),
  .phase_o(phase_o), .ovf_o(ovf_o), .cnt(cnt), .dir_up(dir_up),
  .cmp_buf(cmp_buf), .cmp_act(cmp_act)
);

// File: tb/sine_pwm_gen_tb.sv
`timescale 1ns/1ps
module sine_pwm_gen_tb;
  localparam int PERIOD = 510;
  localparam int TOP_AT = 255;
  localparam int RUN_STATES = 66400;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic       pwm_o;
  logic [6:0] phase_o;
  logic       ovf_o;

  sine_pwm_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .pwm_o(pwm_o), .phase_o(phase_o), .ovf_o(ovf_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int s      = 0;
  int win_k, win_hi, win_rise;
  bit win_open, prev_hi;
  int seen [128];

  function automatic int exp_phase(input int st);
    if (st < 1) return 0;
    return ((st - 1) / PERIOD) % 128;
  endfunction

  function automatic int head_entry(input int n);
    case (n)
      0: return 0;   1: return 0;   2: return 1;   3: return 1;
      4: return 2;   5: return 3;   6: return 4;   7: return 6;
      8: return 7;   9: return 9;   10: return 10; 11: return 12;
      12: return 14; 13: return 16;
      default: return -1;
    endcase
  endfunction

  function automatic int duty_of(input int hi);
    return (hi == 0) ? 0 : (hi + 1) / 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (state %0d)", req, act, exp, s);
    end
  endtask

  task automatic close_window();
    int c, idx;
    c   = duty_of(win_hi);
    idx = win_k % 128;
    check(win_hi == 0 || (win_hi % 2) == 1, "R5 high count odd", win_hi, 2 * c - 1);
    check(win_rise <= 1, "R5 single run", win_rise, 1);
    check(c <= 127, "R7 duty limit", c, 127);
    if (win_k == 0) check(c == 0, "R9 reset compare", c, 0);
    if (win_k < 128) seen[idx] = c;
    else check(c == seen[idx], "R9 repeat after wrap", c, seen[idx]);
    if (idx < 14) check(c == head_entry(idx), "R6 table head", c, head_entry(idx));
  endtask

  task automatic step(input bit e);
    int pos;
    @(negedge clk);
    en = e;
    #1;
    if (exp_phase(s) == 0 && s > PERIOD)
      check(phase_o == 7'(exp_phase(s)), "R4 wrap", phase_o, exp_phase(s));
    else
      check(phase_o == 7'(exp_phase(s)), "R3 phase", phase_o, exp_phase(s));
    if (!e) begin
      check(pwm_o == 1'b0, "R10 pwm quiet", pwm_o, 0);
      check(ovf_o == 1'b0, "R10 ovf quiet", ovf_o, 0);
    end else begin
      check(ovf_o == (s > 0 && (s % PERIOD) == 0), "R2 overflow timing",
            ovf_o, int'(s > 0 && (s % PERIOD) == 0));
      if (s > TOP_AT) begin
        pos = (s - TOP_AT - 1) % PERIOD;
        if (pos == 0) begin
          win_open = 1'b1;
          win_k    = (s - TOP_AT - 1) / PERIOD;
          win_hi   = 0;
          win_rise = 0;
          prev_hi  = 1'b0;
        end
        if (win_open) begin
          if (pwm_o) win_hi++;
          if (pwm_o && !prev_hi) win_rise++;
          prev_hi = pwm_o;
          if (pos == PERIOD - 1) begin
            close_window();
            win_open = 1'b0;
          end
        end
      end
      s++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en    = 1'b0;
    #1;
    check(phase_o == 7'd0, "R1 phase", phase_o, 0);
    check(ovf_o == 1'b0, "R1 ovf", ovf_o, 0);
    check(pwm_o == 1'b0, "R1 pwm", pwm_o, 0);
    repeat (3) @(negedge clk);
    rst_n    = 1'b1;
    s        = 0;
    win_open = 1'b0;
    repeat (4) step(1'b0);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", s, RUN_STATES);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit d_ovf, d_top;
    void'($urandom(32'h5eed_0123));
    rst_n = 1'b0;
    en    = 1'b0;
    d_ovf = 1'b0;
    d_top = 1'b0;
    do_reset();

    while (s < RUN_STATES) begin
      if (!d_top && s == 2 * PERIOD + TOP_AT) begin
        d_top = 1'b1;
        repeat (25) step(1'b0);      // R10 freeze across a carrier top
      end else if (!d_ovf && s == 3 * PERIOD) begin
        d_ovf = 1'b1;
        repeat (25) step(1'b0);      // R10 freeze on an overflow cycle
      end else begin
        step($urandom_range(0, 9) != 0);
      end
    end

    check(seen[64] == 127, "R7 peak", seen[64], 127);
    for (int n = 1; n < 64; n++)
      check(seen[128 - n] == seen[n], "R8 mirror", seen[128 - n], seen[n]);
    for (int n = 1; n <= 64; n++)
      check(seen[n] >= seen[n - 1], "R8 rising half", seen[n], seen[n - 1]);

    do_reset();                      // R1 mid-run reset, then restart
    for (int i = 0; i < 2 * PERIOD + 50; i++) step(1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule